// File: doc/BRIEF.md
# Limp-Mode Clock Source Controller

This controller decides whether the chip runs from its main clock (PLL or oscillator) or from a free-running backup ring-oscillator clock. It runs entirely in the backup clock domain. It watches a toggle signal that comes from the main clock domain. When that toggle stops moving for too long, the controller declares the main clock lost. It then raises a live loss flag and a sticky loss flag that only software can clear.

Software owns two control bits, written through a simple write-enable port: a limp enable and a force-backup request. The same port carries a strobe that clears the sticky flag. Every change of the selected source, in either direction, is paired with one hard-reset request pulse of fixed length. While the chip's hard reset is asserted, a PLL that is not locked, or a main clock that is missing, moves the selection to backup. Once reset has been released, the PLL lock state alone no longer moves the selection.

The block also produces an enable for a secondary engine clock. That enable holds the engine clock low while the PLL is still acquiring lock, unless a configuration input selects the backup clock for the engine. The glitch-free clock mux, the PLL and the oscillator are outside this block. The `hard_rst_in` input is taken as synchronous to `bkp_clk`.

Top module: `limp_clk_ctrl`

## Requirements
- R1: `loss_live` goes to 1 once no synchronized edge of `main_clk_tgl` has been seen for more than `THRESH` backup cycles. It returns to 0 within a few cycles after edges resume.
- R2: `loss_sticky` is set whenever loss is live and then stays set. It clears only on a write with `wr_clr_sticky`=1 while loss is not live.
- R3: With limp enable at 1, a detected loss moves `sel_bkp` to 1 (1 means backup clock) and raises exactly one hard-reset pulse.
- R4: A write of force-backup=1 while limp enable is 1 moves `sel_bkp` to 1 and raises one hard-reset pulse.
- R5: While limp enable is 0, neither force-backup nor a detected loss changes `sel_bkp` or raises a pulse.
- R6: Leaving backup needs force-backup=0 and `loss_sticky`=0 together. If either is still set, `sel_bkp` stays 1. When both are clear, `sel_bkp` returns to 0 with one pulse.
- R7: Writing limp enable to 0 while on backup returns `sel_bkp` to 0 with one pulse.
- R8: While `hard_rst_in`=1, an unlocked PLL moves `sel_bkp` to 1 (with a pulse) and sets `loss_sticky`. The backup selection then holds until the sticky flag is cleared. With a locked PLL and a running main clock, the selection stays on main.
- R9: With `hard_rst_in`=0, a change of `pll_locked` alone never changes `sel_bkp` and raises no pulse.
- R10: `eng_clk_en` is 0 while the synchronized PLL lock is 0 and `bkp_cfg`=0. It is 1 when the PLL is locked or when `bkp_cfg`=1.
- R11: Each hard-reset pulse on `hreset_req` is high for exactly `PULSE_LEN` backup cycles, and `sel_bkp` changes only at the start of a pulse.
- R12: After power-on reset: `sel_bkp`=0, `hreset_req`=0, `loss_live`=0, `loss_sticky`=0, and limp enable=1, force-backup=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bkp_clk | input | 1 | Free-running backup clock; all logic runs on it |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously and released synchronously |
| hard_rst_in | input | 1 | Chip hard reset asserted (active high, synchronous to bkp_clk) |
| pll_locked | input | 1 | PLL lock indication, asynchronous |
| main_clk_tgl | input | 1 | Signal that toggles with the main clock, asynchronous |
| bkp_cfg | input | 1 | Engine clock taken from backup; disables the low hold |
| wr_en | input | 1 | Write strobe for the control bits |
| wr_limp_en | input | 1 | New limp enable value |
| wr_force_bkp | input | 1 | New force-backup value |
| wr_clr_sticky | input | 1 | Clears the sticky loss flag when 1 |
| sel_bkp | output | 1 | Clock select: 1 backup, 0 main |
| hreset_req | output | 1 | Hard-reset request pulse |
| loss_live | output | 1 | Live loss-of-clock status |
| loss_sticky | output | 1 | Sticky loss-of-clock flag |
| eng_clk_en | output | 1 | Engine clock enable; 0 holds it low |

## Verification
A wrong controller state shows on `sel_bkp` and `hreset_req` within one backup cycle of the decision. A missing or doubled transition therefore appears as a wrong pulse count or pulse width, counted on the falling edge of each pulse. A sticky flag that clears too early or never clears shows as a return to the main clock with the wrong timing. That is visible within `PULSE_LEN` cycles after the clearing write. A detector counting off by one moves the rise of `loss_live` by a cycle, so the bench samples well clear of the threshold on both sides.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL     = 2'd0,
    ST_LIMP       = 2'd1,
    ST_RESET_WAIT = 2'd2
  } lcc_state_e;
endpackage

// File: rtl/lcc_sync.sv
module lcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/lcc_loss_det.sv
module lcc_loss_det #(
  parameter int THRESH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_s,
  output logic loss_live
);
  localparam int CW = $clog2(THRESH + 2);
  localparam logic [CW-1:0] SAT = CW'(THRESH + 1);

  logic          tgl_d;
  logic          edge_seen;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          cnt_en;

  assign edge_seen = tgl_s ^ tgl_d;
  assign cnt_en    = edge_seen | (cnt_q != SAT);

  always_comb begin
    cnt_n = cnt_q;
    if (edge_seen)   cnt_n = '0;
    else if (cnt_en) cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgl_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      tgl_d <= tgl_s;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign loss_live = (cnt_q == SAT);

  AST_EDGE_CLEARS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> !loss_live); // R1
endmodule

// File: rtl/lcc_ctrl_regs.sv
module lcc_ctrl_regs #(
  parameter logic LIMP_EN_RST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wd_limp_en,
  input  logic wd_force,
  input  logic wd_clr_sticky,
  input  logic sticky_set,
  output logic limp_en,
  output logic force_bkp,
  output logic sticky
);
  logic sticky_n;
  logic sticky_en;

  assign sticky_en = sticky_set | (wr_en & wd_clr_sticky);

  always_comb begin
    sticky_n = sticky;
    if (sticky_set)                 sticky_n = 1'b1;
    else if (wr_en & wd_clr_sticky) sticky_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      limp_en   <= LIMP_EN_RST;
      force_bkp <= 1'b0;
      sticky    <= 1'b0;
    end else begin
      if (wr_en) begin
        limp_en   <= wd_limp_en;
        force_bkp <= wd_force;
      end
      if (sticky_en) sticky <= sticky_n;
    end
  end

  AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !(wr_en && wd_clr_sticky)) |=> sticky); // R2
endmodule

// File: rtl/lcc_fsm.sv
module lcc_fsm
  import lcc_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic limp_en,
  input  logic force_bkp,
  input  logic sticky,
  input  logic loss_live,
  input  logic rst_bad,
  output logic sel_bkp,
  output logic hreset_req
);
  localparam int PW = (PULSE_LEN > 2) ? $clog2(PULSE_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

  lcc_state_e    state_q, state_n;
  logic          sel_q, sel_n;
  logic [PW-1:0] pcnt_q, pcnt_n;
  logic          go_bkp, go_norm;

  assign go_bkp  = (limp_en & (loss_live | force_bkp)) | rst_bad;
  assign go_norm = !rst_bad & (!limp_en | (!force_bkp & !sticky));

  always_comb begin
    state_n = state_q;
    sel_n   = sel_q;
    pcnt_n  = pcnt_q;
    unique case (state_q)
      ST_NORMAL: if (go_bkp) begin
        state_n = ST_RESET_WAIT;
        sel_n   = 1'b1;
        pcnt_n  = '0;
      end
      ST_LIMP: if (go_norm) begin
        state_n = ST_RESET_WAIT;
        sel_n   = 1'b0;
        pcnt_n  = '0;
      end
      ST_RESET_WAIT: begin
        if (pcnt_q == LAST) state_n = sel_q ? ST_LIMP : ST_NORMAL;
        else                pcnt_n  = pcnt_q + 1'b1;
      end
      default: state_n = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_NORMAL;
      sel_q   <= 1'b0;
      pcnt_q  <= '0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      pcnt_q  <= pcnt_n;
    end
  end

  assign sel_bkp    = sel_q;
  assign hreset_req = (state_q == ST_RESET_WAIT);

  AST_SEL_MOVES_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_q) |-> hreset_req); // R11
  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hreset_req) |-> ($past(pcnt_q) == LAST)); // R11
  AST_LIMP_OFF_HOLDS_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NORMAL && !limp_en && !rst_bad) |=> (state_q == ST_NORMAL)); // R5
  AST_STICKY_HOLDS_LIMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LIMP && sticky && limp_en) |=> (state_q == ST_LIMP)); // R6
endmodule

// File: rtl/limp_clk_ctrl.sv
module limp_clk_ctrl #(
  parameter int   THRESH      = 64,
  parameter int   PULSE_LEN   = 16,
  parameter int   SYNC_STAGES = 2,
  parameter logic LIMP_EN_RST = 1'b1
) (
  input  logic bkp_clk,
  input  logic rst_n,
  input  logic hard_rst_in,
  input  logic pll_locked,
  input  logic main_clk_tgl,
  input  logic bkp_cfg,
  input  logic wr_en,
  input  logic wr_limp_en,
  input  logic wr_force_bkp,
  input  logic wr_clr_sticky,
  output logic sel_bkp,
  output logic hreset_req,
  output logic loss_live,
  output logic loss_sticky,
  output logic eng_clk_en
);
  logic rst_s_n;
  logic pll_s;
  logic tgl_s;
  logic limp_en, force_bkp;
  logic rst_bad;

  lcc_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(bkp_clk), .rst_n(rst_n), .d(1'b1), .q(rst_s_n));

  lcc_sync #(.STAGES(SYNC_STAGES)) u_pll_sync (
    .clk(bkp_clk), .rst_n(rst_s_n), .d(pll_locked), .q(pll_s));

  lcc_sync #(.STAGES(SYNC_STAGES)) u_tgl_sync (
    .clk(bkp_clk), .rst_n(rst_s_n), .d(main_clk_tgl), .q(tgl_s));

  lcc_loss_det #(.THRESH(THRESH)) u_det (
    .clk(bkp_clk), .rst_n(rst_s_n), .tgl_s(tgl_s), .loss_live(loss_live));

  assign rst_bad = hard_rst_in & (!pll_s | loss_live);

  lcc_ctrl_regs #(.LIMP_EN_RST(LIMP_EN_RST)) u_regs (
    .clk(bkp_clk), .rst_n(rst_s_n), .wr_en(wr_en),
    .wd_limp_en(wr_limp_en), .wd_force(wr_force_bkp),
    .wd_clr_sticky(wr_clr_sticky), .sticky_set(loss_live | rst_bad),
    .limp_en(limp_en), .force_bkp(force_bkp), .sticky(loss_sticky));

  lcc_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
    .clk(bkp_clk), .rst_n(rst_s_n), .limp_en(limp_en),
    .force_bkp(force_bkp), .sticky(loss_sticky), .loss_live(loss_live),
    .rst_bad(rst_bad), .sel_bkp(sel_bkp), .hreset_req(hreset_req));

  assign eng_clk_en = pll_s | bkp_cfg;

  AST_NO_SWITCH_ON_LOCK_ALONE: assert property (@(posedge bkp_clk) disable iff (!rst_s_n)
    (!hard_rst_in && !hreset_req && !loss_live && !$stable(pll_s) && !sel_bkp && !force_bkp)
      |=> !sel_bkp); // R9
endmodule

// File: tb/limp_clk_ctrl_test.sv
module limp_clk_ctrl_test;
  localparam int TH = 16;
  localparam int PL = 8;

  logic clk = 1'b0;
  logic rst_n, hard_rst_in, pll_locked, main_clk_tgl, bkp_cfg;
  logic wr_en, wr_limp_en, wr_force_bkp, wr_clr_sticky;
  logic sel_bkp, hreset_req, loss_live, loss_sticky, eng_clk_en;
  logic main_run;
  int tests = 0, fails = 0;
  int pulses = 0, wcur = 0, last_w = 0, exp_p = 0;
  logic hr_prev = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  limp_clk_ctrl #(.THRESH(TH), .PULSE_LEN(PL)) uut (
    .bkp_clk(clk), .rst_n(rst_n), .hard_rst_in(hard_rst_in),
    .pll_locked(pll_locked), .main_clk_tgl(main_clk_tgl), .bkp_cfg(bkp_cfg),
    .wr_en(wr_en), .wr_limp_en(wr_limp_en), .wr_force_bkp(wr_force_bkp),
    .wr_clr_sticky(wr_clr_sticky), .sel_bkp(sel_bkp), .hreset_req(hreset_req),
    .loss_live(loss_live), .loss_sticky(loss_sticky), .eng_clk_en(eng_clk_en));

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (hreset_req) wcur = wcur + 1;
    if (!hreset_req && hr_prev) begin
      pulses = pulses + 1;
      last_w = wcur;
      wcur   = 0;
    end
    hr_prev = hreset_req;
  end

  initial begin
    main_clk_tgl = 1'b0;
    forever begin
      @(negedge clk);
      if (main_run) main_clk_tgl = ~main_clk_tgl;
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic le, input logic fb, input logic clr);
    @(negedge clk);
    wr_en = 1'b1; wr_limp_en = le; wr_force_bkp = fb; wr_clr_sticky = clr;
    @(negedge clk);
    wr_en = 1'b0; wr_clr_sticky = 1'b0;
  endtask

  task automatic t_reset;
    chk("R12 sel", sel_bkp, 0);
    chk("R12 hreset", hreset_req, 0);
    chk("R12 loss", loss_live, 0);
    chk("R12 sticky", loss_sticky, 0);
    chk("R10 eng locked", eng_clk_en, 1);
  endtask

  task automatic t_disabled;
    wr(1'b0, 1'b1, 1'b0);
    main_run = 1'b0;
    cyc(40);
    chk("R1 loss after stop", loss_live, 1);
    chk("R2 sticky set", loss_sticky, 1);
    chk("R5 sel held", sel_bkp, 0);
    chk("R5 no pulse", pulses, exp_p);
    main_run = 1'b1;
    cyc(10);
    chk("R1 loss cleared", loss_live, 0);
    chk("R2 sticky held", loss_sticky, 1);
    wr(1'b0, 1'b0, 1'b1);
    cyc(3);
    chk("R2 sticky cleared", loss_sticky, 0);
  endtask

  task automatic t_force;
    wr(1'b1, 1'b1, 1'b0);
    cyc(30);
    exp_p++;
    chk("R4 forced backup", sel_bkp, 1);
    chk("R4 one pulse", pulses, exp_p);
    chk("R11 width", last_w, PL);
    wr(1'b1, 1'b0, 1'b0);
    cyc(30);
    exp_p++;
    chk("R6 back to main", sel_bkp, 0);
    chk("R6 pulse", pulses, exp_p);
    chk("R11 width", last_w, PL);
  endtask

  task automatic t_loss_limp;
    main_run = 1'b0;
    cyc(60);
    exp_p++;
    chk("R3 backup on loss", sel_bkp, 1);
    chk("R3 one pulse", pulses, exp_p);
    main_run = 1'b1;
    cyc(10);
    chk("R1 loss cleared", loss_live, 0);
    chk("R6 sticky keeps backup", sel_bkp, 1);
    wr(1'b1, 1'b1, 1'b1);
    cyc(20);
    chk("R6 sticky cleared", loss_sticky, 0);
    chk("R6 force keeps backup", sel_bkp, 1);
    chk("R6 no pulse", pulses, exp_p);
    wr(1'b1, 1'b0, 1'b0);
    cyc(30);
    exp_p++;
    chk("R6 both clear", sel_bkp, 0);
    chk("R6 exit pulse", pulses, exp_p);
  endtask

  task automatic t_limp_off;
    wr(1'b1, 1'b1, 1'b0);
    cyc(30);
    exp_p++;
    chk("R4 backup", sel_bkp, 1);
    wr(1'b0, 1'b1, 1'b0);
    cyc(30);
    exp_p++;
    chk("R7 main after disable", sel_bkp, 0);
    chk("R7 pulse", pulses, exp_p);
    cyc(20);
    chk("R5 force ignored", sel_bkp, 0);
    chk("R5 no pulse", pulses, exp_p);
    wr(1'b1, 1'b0, 1'b0);
    cyc(5);
  endtask

  task automatic t_hreset;
    hard_rst_in = 1'b1;
    cyc(10);
    chk("R8 locked stays main", sel_bkp, 0);
    chk("R8 no pulse", pulses, exp_p);
    pll_locked = 1'b0;
    cyc(30);
    exp_p++;
    chk("R8 unlocked to backup", sel_bkp, 1);
    chk("R8 pulse", pulses, exp_p);
    chk("R8 sticky", loss_sticky, 1);
    chk("R10 eng held low", eng_clk_en, 0);
    hard_rst_in = 1'b0;
    cyc(5);
    pll_locked = 1'b1;
    cyc(20);
    chk("R8 backup held", sel_bkp, 1);
    wr(1'b1, 1'b0, 1'b1);
    cyc(30);
    exp_p++;
    chk("R8 main after clear", sel_bkp, 0);
    chk("R8 exit pulse", pulses, exp_p);
  endtask

  task automatic t_pll_after;
    pll_locked = 1'b0;
    cyc(30);
    chk("R9 no switch", sel_bkp, 0);
    chk("R9 no pulse", pulses, exp_p);
    chk("R10 eng low", eng_clk_en, 0);
    bkp_cfg = 1'b1;
    cyc(2);
    chk("R10 cfg enables", eng_clk_en, 1);
    bkp_cfg = 1'b0;
    pll_locked = 1'b1;
    cyc(5);
    chk("R10 relocked", eng_clk_en, 1);
    chk("R9 still main", sel_bkp, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hard_rst_in = 1'b0; pll_locked = 1'b1; bkp_cfg = 1'b0;
    wr_en = 1'b0; wr_limp_en = 1'b0; wr_force_bkp = 1'b0; wr_clr_sticky = 1'b0;
    main_run = 1'b1;
    cyc(4);
    rst_n = 1'b1;
    cyc(10);
    t_reset;
    t_disabled;
    wr(1'b1, 1'b0, 1'b0);
    cyc(5);
    t_force;
    t_loss_limp;
    t_limp_off;
    t_hreset;
    t_pll_after;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule